// File: doc/BRIEF.md
# Two-Level Cell Header Address Compressor

This block turns the path identifiers of a received cell header into a dense 16-bit local channel number. It then turns that number into the address of the receive channel table that belongs to it. A single lookup takes the PHY number, the path identifier (VPI) and the circuit identifier (VCI), and walks two tables in memory.

The first table is indexed by the VPI bits that a programmable run-of-ones mask selects. Its 32-bit entry supplies a second mask and an offset. That second mask selects VCI bits, which index a table of 16-bit channel numbers placed at the second-level base plus the offset. Some lookups cannot resolve: a null first-level entry, an empty second mask, a malformed mask or a reserved channel value. These lookups are steered to a per-PHY raw-cell channel.

Both the request and the result use valid/ready handshakes. The request side holds `req_ready` low from acceptance until the result handshake completes, so there is never more than one lookup in flight. The result stays on `rsp_*` unchanged while `rsp_ready` is low. Table reads use a request port with valid/ready back-pressure: the address is held while `rd_ready` is low. The word returns on `rd_rdata` in the MEM_LAT-th cycle after the edge that accepted the read. The configuration inputs must stay stable while a lookup is in progress.

Top module: `vc_addr_compress`

## Requirements
- R1: The first-level index is formed by taking the VPI bits under `cfg_fl_mask` and right-justifying them. The block reads the word at `cfg_fl_base + index*4`. In that word, bits [15:0] are the second mask and bits [31:16] are the offset.
- R2: A first-level word of all zeros is null. The block issues no second read and returns the raw channel with `rsp_raw`=1 and `rsp_err`=0.
- R3: A non-null first-level word whose second mask is zero returns the raw channel with `rsp_raw`=1 and `rsp_err`=0, after a single read.
- R4: The second read goes to `cfg_sl_base + off + index*2`. Here `off` is the offset, multiplied by 4 when `cfg_sl_scale`=1, and `index` is the VCI bits under the second mask, right-justified. The channel is taken from bits [15:0] of the returned word when address bit 1 is 0, and from bits [31:16] when it is 1.
- R5: The RCT address is `cfg_ct_base + chan*64` for channels 0 to 31, and `cfg_ect_base + chan*64` for channels 32 and above.
- R6: The raw channel is the PHY number when `cfg_multi_phy`=1, and 0 when it is 0.
- R7: A second-level value of 0xFFFF returns the raw channel with `rsp_raw`=1 and `rsp_err`=1.
- R8: A first-level or second mask that is non-zero but not one contiguous run of ones returns the raw channel with `rsp_raw`=1 and `rsp_err`=1. A bad first-level mask causes no read at all. `rsp_err`=1 always comes with `rsp_raw`=1.
- R9: VPI and VCI bits outside the masks have no effect on the result.
- R10: `req_ready` is low from the cycle after a request is accepted until the cycle after the result handshake.
- R11: While `rsp_valid`=1 and `rsp_ready`=0, every `rsp_*` output holds its value.
- R12: While `rd_valid`=1 and `rd_ready`=0, `rd_valid` and `rd_addr` hold. Read data is taken exactly MEM_LAT cycles after acceptance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_fl_base | input | ADDR_W | First-level table base |
| cfg_sl_base | input | ADDR_W | Second-level table base |
| cfg_fl_mask | input | VPI_W | First-level VPI mask |
| cfg_sl_scale | input | 1 | Multiply the second-level offset by 4 |
| cfg_multi_phy | input | 1 | Raw channel follows the PHY number |
| cfg_ct_base | input | ADDR_W | On-chip channel table base |
| cfg_ect_base | input | ADDR_W | External channel table base |
| req_valid | input | 1 | Lookup request valid |
| req_ready | output | 1 | Block can accept a request |
| req_phy | input | PHY_W | PHY number |
| req_vpi | input | VPI_W | Path identifier |
| req_vci | input | 16 | Circuit identifier |
| rd_valid | output | 1 | Table read request valid |
| rd_ready | input | 1 | Memory accepts the read |
| rd_addr | output | ADDR_W | Byte address of the read |
| rd_rdata | input | 32 | Word read from memory, aligned down to 4 bytes |
| rsp_valid | output | 1 | Result valid |
| rsp_ready | input | 1 | Consumer takes the result |
| rsp_chan | output | 16 | Local channel number |
| rsp_rct_addr | output | ADDR_W | Receive channel table address |
| rsp_raw | output | 1 | Fell back to the raw-cell channel |
| rsp_err | output | 1 | Malformed mask or reserved channel |

## Verification
A corrupted walk state shows up at the ports within one lookup. The symptoms are a read count other than 0, 1 or 2, a wrong channel, or a hang in which `rsp_valid` never rises. A latency counter that is off by one captures a word from the wrong cycle. The bench drives a poison pattern outside the valid data cycle, so that word turns into a wrong channel at once. A wrong half select or wrong index gathering changes the channel of the very lookup that exposes it. The bench stalls the read port on every third cycle, so a lost hold on `rd_addr` would also surface as a wrong result.

// File: rtl/vcc_pkg.sv
package vcc_pkg;
  localparam int HALF_W = 16;
  localparam int WORD_W = 32;
  localparam logic [HALF_W-1:0] CHAN_RESERVED = 16'hFFFF;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_FL_REQ,
    ST_FL_WAIT,
    ST_SL_REQ,
    ST_SL_WAIT,
    ST_RESP
  } walk_st_e;
endpackage

// File: rtl/vcc_mask_gather.sv
module vcc_mask_gather #(
  parameter int W = 16
) (
  input  logic [W-1:0] value,
  input  logic [W-1:0] mask,
  output logic [W-1:0] index,
  output logic         contiguous,
  output logic         empty
);
  localparam int SH_W = $clog2(W) + 1;

  logic [SH_W-1:0] tz;
  logic [W-1:0]    norm;
  logic            found;

  always_comb begin
    tz    = '0;
    found = 1'b0;
    for (int i = 0; i < W; i++) begin
      if (!found && mask[i]) begin
        tz    = SH_W'(i);
        found = 1'b1;
      end
    end
    norm       = mask >> tz;
    index      = (value & mask) >> tz;
    empty      = (mask == '0);
    contiguous = empty || ((norm & (norm + W'(1))) == '0);
  end
endmodule

// File: rtl/vcc_rct_map.sv
module vcc_rct_map #(
  parameter int ADDR_W      = 32,
  parameter int CH_W        = 16,
  parameter int ONCHIP_LAST = 31,
  parameter int SLOT_SHIFT  = 6
) (
  input  logic [CH_W-1:0]   chan,
  input  logic [ADDR_W-1:0] ct_base,
  input  logic [ADDR_W-1:0] ect_base,
  output logic [ADDR_W-1:0] rct_addr
);
  logic onchip;

  always_comb begin
    onchip   = (chan <= CH_W'(ONCHIP_LAST));
    rct_addr = (onchip ? ct_base : ect_base) + (ADDR_W'(chan) << SLOT_SHIFT);
  end
endmodule

// File: rtl/vc_addr_compress.sv
module vc_addr_compress
  import vcc_pkg::*;
#(
  parameter int ADDR_W  = 32,
  parameter int VPI_W   = 12,
  parameter int PHY_W   = 5,
  parameter int MEM_LAT = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] cfg_fl_base,
  input  logic [ADDR_W-1:0] cfg_sl_base,
  input  logic [VPI_W-1:0]  cfg_fl_mask,
  input  logic              cfg_sl_scale,
  input  logic              cfg_multi_phy,
  input  logic [ADDR_W-1:0] cfg_ct_base,
  input  logic [ADDR_W-1:0] cfg_ect_base,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [PHY_W-1:0]  req_phy,
  input  logic [VPI_W-1:0]  req_vpi,
  input  logic [15:0]       req_vci,
  output logic              rd_valid,
  input  logic              rd_ready,
  output logic [ADDR_W-1:0] rd_addr,
  input  logic [31:0]       rd_rdata,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [15:0]       rsp_chan,
  output logic [ADDR_W-1:0] rsp_rct_addr,
  output logic              rsp_raw,
  output logic              rsp_err
);
  localparam int CNT_W = $clog2(MEM_LAT + 1);

  walk_st_e           state;
  logic [PHY_W-1:0]   phy_q;
  logic [VPI_W-1:0]   vpi_q;
  logic [HALF_W-1:0]  vci_q;
  logic [WORD_W-1:0]  fl_ent;
  logic [CNT_W-1:0]   lat_cnt;
  logic [HALF_W-1:0]  res_chan;
  logic               res_raw, res_err;

  // first level: VPI under the global mask
  logic [VPI_W-1:0]   fl_idx;
  logic               fl_contig, fl_empty;
  vcc_mask_gather #(.W(VPI_W)) u_fl_gather (
    .value(vpi_q), .mask(cfg_fl_mask),
    .index(fl_idx), .contiguous(fl_contig), .empty(fl_empty)
  );

  // second level: VCI under the mask held in the first-level word
  logic [HALF_W-1:0]  sl_mask, sl_off, sl_idx;
  logic               sl_contig, sl_empty;
  assign sl_mask = fl_ent[HALF_W-1:0];
  assign sl_off  = fl_ent[WORD_W-1:HALF_W];
  vcc_mask_gather #(.W(HALF_W)) u_sl_gather (
    .value(vci_q), .mask(sl_mask),
    .index(sl_idx), .contiguous(sl_contig), .empty(sl_empty)
  );

  logic [ADDR_W-1:0] fl_addr, sl_addr, sl_off_eff;
  logic [HALF_W-1:0] raw_chan, sl_val;
  logic              lat_done;

  always_comb begin
    fl_addr    = cfg_fl_base + (ADDR_W'(fl_idx) << 2);
    sl_off_eff = cfg_sl_scale ? (ADDR_W'(sl_off) << 2) : ADDR_W'(sl_off);
    sl_addr    = cfg_sl_base + sl_off_eff + (ADDR_W'(sl_idx) << 1);
    sl_val     = sl_addr[1] ? rd_rdata[WORD_W-1:HALF_W] : rd_rdata[HALF_W-1:0];
    raw_chan   = cfg_multi_phy ? HALF_W'(phy_q) : '0;
    lat_done   = (lat_cnt == CNT_W'(MEM_LAT));
  end

  // second read is skipped for null words, empty and broken masks
  logic sl_go;
  assign sl_go = (fl_ent != '0) && !sl_empty && sl_contig;

  always_comb begin
    rd_valid = 1'b0;
    rd_addr  = fl_addr;
    if (state == ST_FL_REQ) begin
      rd_valid = fl_contig;
    end else if (state == ST_SL_REQ) begin
      rd_valid = sl_go;
      rd_addr  = sl_addr;
    end
  end

  assign req_ready = (state == ST_IDLE);
  assign rsp_valid = (state == ST_RESP);
  assign rsp_chan  = res_chan;
  assign rsp_raw   = res_raw;
  assign rsp_err   = res_err;

  vcc_rct_map #(.ADDR_W(ADDR_W), .CH_W(HALF_W)) u_rct_map (
    .chan(res_chan), .ct_base(cfg_ct_base), .ect_base(cfg_ect_base),
    .rct_addr(rsp_rct_addr)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      phy_q    <= '0;
      vpi_q    <= '0;
      vci_q    <= '0;
      fl_ent   <= '0;
      lat_cnt  <= '0;
      res_chan <= '0;
      res_raw  <= 1'b0;
      res_err  <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: if (req_valid) begin
          phy_q <= req_phy;
          vpi_q <= req_vpi;
          vci_q <= req_vci;
          state <= ST_FL_REQ;
        end
        ST_FL_REQ: begin
          if (!fl_contig) begin
            res_chan <= raw_chan;
            res_raw  <= 1'b1;
            res_err  <= 1'b1;
            state    <= ST_RESP;
          end else if (rd_ready) begin
            lat_cnt <= CNT_W'(1);
            state   <= ST_FL_WAIT;
          end
        end
        ST_FL_WAIT: begin
          if (lat_done) begin
            fl_ent <= rd_rdata;
            state  <= ST_SL_REQ;
          end else begin
            lat_cnt <= lat_cnt + CNT_W'(1);
          end
        end
        ST_SL_REQ: begin
          if (!sl_go) begin
            res_chan <= raw_chan;
            res_raw  <= 1'b1;
            res_err  <= (fl_ent != '0) && !sl_empty && !sl_contig;
            state    <= ST_RESP;
          end else if (rd_ready) begin
            lat_cnt <= CNT_W'(1);
            state   <= ST_SL_WAIT;
          end
        end
        ST_SL_WAIT: begin
          if (lat_done) begin
            if (sl_val == CHAN_RESERVED) begin
              res_chan <= raw_chan;
              res_raw  <= 1'b1;
              res_err  <= 1'b1;
            end else begin
              res_chan <= sl_val;
              res_raw  <= 1'b0;
              res_err  <= 1'b0;
            end
            state <= ST_RESP;
          end else begin
            lat_cnt <= lat_cnt + CNT_W'(1);
          end
        end
        ST_RESP: if (rsp_ready) state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R10: an accepted request closes the request side
  assert_one_lookup_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);

  // R11: a stalled result holds every field
  assert_rsp_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_chan)
      && $stable(rsp_raw) && $stable(rsp_err)));

  // R12: a stalled read keeps its address
  assert_rd_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && !rd_ready) |=> (rd_valid && $stable(rd_addr)));

  // R8: an error is always a raw fallback
  assert_err_is_raw_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_err) |-> rsp_raw);

  // R1: first-level reads keep the base alignment of 4-byte entries
  assert_fl_align_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && state == ST_FL_REQ) |-> (rd_addr[1:0] == cfg_fl_base[1:0]));

  // R6: in single-PHY mode every raw result is channel 0
  assert_single_phy_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_raw && !cfg_multi_phy) |-> (rsp_chan == '0));
endmodule

// File: tb/test_vc_addr_compress.sv
module test_vc_addr_compress;
  localparam int LAT = 2;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] cfg_fl_base = 32'h1000, cfg_sl_base = 32'h8000;
  logic [11:0] cfg_fl_mask = 12'h0F0;
  logic        cfg_sl_scale = 1'b0, cfg_multi_phy = 1'b1;
  logic [31:0] cfg_ct_base = 32'h2000, cfg_ect_base = 32'h0010_0000;
  logic        req_valid = 1'b0, req_ready;
  logic [4:0]  req_phy = '0;
  logic [11:0] req_vpi = '0;
  logic [15:0] req_vci = '0;
  logic        rd_valid, rd_ready = 1'b1;
  logic [31:0] rd_addr, rd_rdata;
  logic        rsp_valid, rsp_ready = 1'b0;
  logic [15:0] rsp_chan;
  logic [31:0] rsp_rct_addr;
  logic        rsp_raw, rsp_err;

  int checks = 0, failures = 0, cyc = 0, rd_count = 0;
  logic stall_en = 1'b0;

  always #5 clk = ~clk;

  vc_addr_compress #(.MEM_LAT(LAT)) i_vc_addr_compress (.*);

  // memory model: fixed latency, poison outside the data cycle
  logic [31:0] mem [logic [31:0]];
  logic        pv [LAT];
  logic [31:0] pa [LAT];

  function automatic logic [31:0] mem_rd(input logic [31:0] a);
    logic [31:0] w = {a[31:2], 2'b00};
    return mem.exists(w) ? mem[w] : 32'h0;
  endfunction

  always @(posedge clk) begin
    cyc <= cyc + 1;
    pv[0] <= rd_valid && rd_ready;
    pa[0] <= rd_addr;
    for (int i = 1; i < LAT; i++) begin
      pv[i] <= pv[i-1];
      pa[i] <= pa[i-1];
    end
    if (rd_valid && rd_ready) rd_count <= rd_count + 1;
  end
  assign rd_rdata = pv[LAT-1] ? mem_rd(pa[LAT-1]) : 32'hDEAD_BEEF;

  always @(negedge clk) rd_ready <= !stall_en || (cyc % 3 != 0);

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  typedef struct packed {
    logic [11:0] vpi;
    logic [15:0] vci;
    logic [4:0]  phy;
    logic [15:0] chan;
    logic [31:0] rct;
    logic        raw;
    logic        err;
    logic [1:0]  reads;
  } vec_t;

  localparam int NV = 10;
  localparam vec_t VECS [NV] = '{
    '{12'h010, 16'h0000, 5'd1, 16'd5,      32'h0000_2140, 1'b0, 1'b0, 2'd2}, // R1 R4 low half
    '{12'h010, 16'h0002, 5'd1, 16'd31,     32'h0000_27C0, 1'b0, 1'b0, 2'd2}, // R5 last on-chip
    '{12'h010, 16'h0003, 5'd1, 16'd37,     32'h0010_0940, 1'b0, 1'b0, 2'd2}, // R4 high half
    '{12'h010, 16'h0004, 5'd1, 16'd32,     32'h0010_0800, 1'b0, 1'b0, 2'd2}, // R5 first external
    '{12'h815, 16'hFFC7, 5'd1, 16'd0,      32'h0000_2000, 1'b0, 1'b0, 2'd2}, // R9 outside bits
    '{12'h020, 16'h1234, 5'd7, 16'd7,      32'h0000_21C0, 1'b1, 1'b0, 2'd1}, // R2 null word
    '{12'h030, 16'h0000, 5'd0, 16'd0,      32'h0000_2000, 1'b1, 1'b0, 2'd1}, // R3 empty mask
    '{12'h040, 16'h0000, 5'd3, 16'd3,      32'h0000_20C0, 1'b1, 1'b1, 2'd1}, // R8 broken mask
    '{12'h010, 16'h0001, 5'd9, 16'd9,      32'h0000_2240, 1'b1, 1'b1, 2'd2}, // R7 reserved
    '{12'h050, 16'h1234, 5'd2, 16'h1234,   32'h0014_8D00, 1'b0, 1'b0, 2'd2}  // R1 wide mask
  };

  logic [15:0] o_chan;
  logic [31:0] o_rct;
  logic        o_raw, o_err;
  int          o_reads;

  task automatic lookup(input logic [11:0] vpi, input logic [15:0] vci,
                        input logic [4:0] phy, input int hold);
    int start;
    @(negedge clk);
    req_vpi = vpi; req_vci = vci; req_phy = phy; req_valid = 1'b1;
    start = rd_count;
    while (!req_ready) @(negedge clk);
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    while (!rsp_valid) @(negedge clk);
    o_chan = rsp_chan; o_rct = rsp_rct_addr; o_raw = rsp_raw; o_err = rsp_err;
    for (int h = 0; h < hold; h++) begin
      @(negedge clk);
      chk("R11 hold chan", {16'h0, rsp_chan}, {16'h0, o_chan});
      chk("R11 hold valid", {31'h0, rsp_valid}, 32'h1);
      chk("R10 busy ready", {31'h0, req_ready}, 32'h0);
    end
    rsp_ready = 1'b1;
    @(negedge clk);
    rsp_ready = 1'b0;
    o_reads = rd_count - start;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    mem[32'h1004] = {16'h0100, 16'h003F};
    mem[32'h1008] = 32'h0;
    mem[32'h100C] = {16'h0040, 16'h0000};
    mem[32'h1010] = {16'h0000, 16'h0A00};
    mem[32'h1014] = {16'h0200, 16'hFF00};
    mem[32'h1018] = {16'h0040, 16'h000F};
    mem[32'h8100] = {16'hFFFF, 16'd5};
    mem[32'h8104] = {16'd37, 16'd31};
    mem[32'h8108] = {16'h0000, 16'd32};
    mem[32'h810C] = 32'h0;
    mem[32'h8224] = {16'h0000, 16'h1234};

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R10 reset req_ready", {31'h0, req_ready}, 32'h1);
    chk("R11 reset rsp_valid", {31'h0, rsp_valid}, 32'h0);
    chk("R12 reset rd_valid", {31'h0, rd_valid}, 32'h0);

    stall_en = 1'b1;
    for (int v = 0; v < NV; v++) begin
      lookup(VECS[v].vpi, VECS[v].vci, VECS[v].phy, 0);
      chk($sformatf("vec%0d chan", v), {16'h0, o_chan}, {16'h0, VECS[v].chan});
      chk($sformatf("vec%0d rct R5", v), o_rct, VECS[v].rct);
      chk($sformatf("vec%0d raw", v), {31'h0, o_raw}, {31'h0, VECS[v].raw});
      chk($sformatf("vec%0d err", v), {31'h0, o_err}, {31'h0, VECS[v].err});
      chk($sformatf("vec%0d reads R2 R12", v), o_reads, VECS[v].reads);
    end
    stall_en = 1'b0;

    // R6 single-PHY raw channel
    cfg_multi_phy = 1'b0;
    lookup(12'h020, 16'h0, 5'd7, 0);
    chk("R6 single-phy chan", {16'h0, o_chan}, 32'h0);
    chk("R6 single-phy rct", o_rct, 32'h2000);
    cfg_multi_phy = 1'b1;

    // R4 scaled offset: 0x40*4 + 2*2 -> 0x8104 low half
    cfg_sl_scale = 1'b1;
    lookup(12'h060, 16'h0002, 5'd1, 0);
    chk("R4 scaled chan", {16'h0, o_chan}, 32'd31);
    cfg_sl_scale = 1'b0;
    lookup(12'h060, 16'h0002, 5'd1, 0);
    chk("R4 unscaled chan", {16'h0, o_chan}, 32'd0);

    // R8 broken first-level mask: no read
    cfg_fl_mask = 12'h0A0;
    lookup(12'h010, 16'h0, 5'd4, 0);
    chk("R8 fl mask chan", {16'h0, o_chan}, 32'd4);
    chk("R8 fl mask err", {31'h0, o_err}, 32'h1);
    chk("R8 fl mask reads", o_reads, 0);
    cfg_fl_mask = 12'h0F0;

    // R11 R10 result back-pressure
    lookup(12'h010, 16'h0003, 5'd1, 4);
    chk("R11 held result", {16'h0, o_chan}, 32'd37);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule